// File: doc/BRIEF.md
# Programmable Key Chatter Filter

This block removes contact bounce from a bank of key inputs before they reach edge-sensitive interrupt logic. The keys are split into groups of four. Each group has a 3-bit code. Code 0 passes the synchronized inputs straight through. Any other code selects a check time, which is a power-of-two number of clock cycles. A filtered output takes a new level only after the raw input has held that level long enough, so a short glitch never reaches the edge detector.

Every input first passes through a two-flop synchronizer. Each group then samples its synchronized inputs on a tick that repeats once per check time. An output bit flips on a tick only when that tick's sample and the previous tick's sample agree, and both differ from the present output. A pulse no longer than the check time is therefore rejected. A level that holds for twice the check time is accepted.

When a group's code changes, its tick counter restarts and its outputs hold their values. When a group leaves pass-through mode, its filter state is seeded from the present synchronized inputs, so the output does not jump.

Top module: `key_chatter_filter`

## Requirements
- R1: While reset is held and directly after it is released, every `key_out` bit is 0, and both group codes are treated as 0 (pass-through).
- R2: A group whose code is 0 drives its `key_out` bits with `key_in` delayed by exactly two clock cycles.
- R3: Bits 3:0 of `key_in`/`key_out` are governed only by `grp_code[2:0]`, and bits 7:4 only by `grp_code[5:3]`. Filtering one group does not change the timing of the other.
- R4: A code c in 1..7 sets the check time to 2^(BASE_SHIFT+c-1) clock cycles. With the default BASE_SHIFT of 8 this gives 256 to 16384 cycles. The group's tick repeats with exactly this period.
- R5: In a filtering group, a `key_in` pulse lasting at most one check time never changes the corresponding `key_out` bit.
- R6: In a filtering group, a new `key_in` level held for at least two check times plus a few cycles is accepted. The output follows more than one check time and at most two check times plus three cycles after the input edge.
- R7: After a group's code changes from one filtering value to another, that group's tick counter restarts and its `key_out` bits hold their values for at least one new check time, even if the inputs change.
- R8: When a group's code changes from 0 to a filtering value, its `key_out` bits continue from the current synchronized inputs without a glitch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the time base for the check time |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | NUM_GROUPS*GROUP_W (8) | Raw key levels, asynchronous to clk |
| grp_code | input | NUM_GROUPS*3 (6) | Per-group check-time code; bits 3g+2:3g serve group g |
| key_out | output | NUM_GROUPS*GROUP_W (8) | Filtered key levels |

## Verification
The bench builds the block with BASE_SHIFT set to 2. This shrinks the seven check times to 4 through 256 cycles, so every code can be exercised in turn: the rejected pulse, the accepted level and the seeding from pass-through. The group width, the group count and the code-to-period rule are the same as in the default build. A behavioural model of the counting rule follows every clock, so the exact cycle of each accepted change is compared for all seven codes and for both groups.

// File: rtl/kcf_pkg.sv
package kcf_pkg;
  localparam int unsigned CODE_W  = 3;
  // largest exponent offset above BASE_SHIFT (code 7 -> +6)
  localparam int unsigned MAX_EXP = 6;

  // check time in clock cycles for a code; 0 means pass-through
  function automatic int unsigned check_cycles(input logic [CODE_W-1:0] code,
                                               input int unsigned base_shift);
    if (code == '0) return 0;
    return 32'd1 << (base_shift + int'(code) - 1);
  endfunction
endpackage

// File: rtl/kcf_sync.sv
module kcf_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta     <= '0;
      sync_out <= '0;
    end else begin
      meta     <= async_in;
      sync_out <= meta;
    end
  end
endmodule

// File: rtl/kcf_group.sv
module kcf_group #(
  parameter int unsigned GROUP_W    = 4,
  parameter int unsigned BASE_SHIFT = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [kcf_pkg::CODE_W-1:0] code,
  input  logic [GROUP_W-1:0]        sync_in,
  output logic [GROUP_W-1:0]        filt_out
);
  localparam int unsigned CNT_W = BASE_SHIFT + kcf_pkg::MAX_EXP;

  logic [kcf_pkg::CODE_W-1:0] code_q;
  logic [CNT_W-1:0]           cnt;
  logic [CNT_W-1:0]           last_cnt;
  logic [GROUP_W-1:0]         samp;
  logic [GROUP_W-1:0]         filt;
  logic [GROUP_W-1:0]         accept;
  logic                       code_chg;
  logic                       bypass_q;
  logic                       tick;

  // named events for the assertions
  assign code_chg = (code != code_q);
  assign bypass_q = (code_q == '0);
  assign last_cnt = CNT_W'(kcf_pkg::check_cycles(code, BASE_SHIFT) - 1);
  assign tick     = !code_chg && (code != '0) && (cnt == last_cnt);
  // agree with previous tick sample and differ from present output
  assign accept   = ~(sync_in ^ samp) & (sync_in ^ filt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt    <= '0;
      samp   <= '0;
      filt   <= '0;
    end else begin
      code_q <= code;
      if (code_chg) begin
        cnt <= '0;
        if (bypass_q) begin
          filt <= sync_in;
          samp <= sync_in;
        end else begin
          samp <= filt;
        end
      end else if (code == '0) begin
        cnt  <= '0;
        filt <= sync_in;
        samp <= sync_in;
      end else if (tick) begin
        cnt  <= '0;
        samp <= sync_in;
        filt <= filt ^ accept;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign filt_out = bypass_q ? sync_in : filt;

  // counter never passes the window of the active code
  p_cnt_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_chg && code != '0) |-> (cnt <= last_cnt));

  // filtered state moves only on a tick of a steady filtering code
  p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_q && (!tick || code_chg)) |=> $stable(filt));

  // a write between filtering codes restarts the count and holds outputs
  p_restart_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_chg && !bypass_q) |=> (cnt == '0) && $stable(filt));

  // leaving or staying in pass-through seeds state from the synced input
  p_seed_from_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_q |=> (filt == $past(sync_in)) && (samp == $past(sync_in)));
endmodule

// File: rtl/key_chatter_filter.sv
module key_chatter_filter #(
  parameter int unsigned GROUP_W    = 4,
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned BASE_SHIFT = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [NUM_GROUPS*GROUP_W-1:0]           key_in,
  input  logic [NUM_GROUPS*kcf_pkg::CODE_W-1:0]   grp_code,
  output logic [NUM_GROUPS*GROUP_W-1:0]           key_out
);
  localparam int unsigned NUM_KEYS = NUM_GROUPS * GROUP_W;
  localparam int unsigned CW       = kcf_pkg::CODE_W;

  logic [NUM_KEYS-1:0] key_sync;

  kcf_sync #(.W(NUM_KEYS)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (key_in),
    .sync_out (key_sync)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    kcf_group #(.GROUP_W(GROUP_W), .BASE_SHIFT(BASE_SHIFT)) i_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .code     (grp_code[g*CW +: CW]),
      .sync_in  (key_sync[g*GROUP_W +: GROUP_W]),
      .filt_out (key_out[g*GROUP_W +: GROUP_W])
    );
  end

  // outputs are low for the whole first cycle after reset
  p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (key_out == '0));
endmodule

// File: tb/test_key_chatter_filter.sv
module test_key_chatter_filter;
  localparam int SH = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] key_in = '0;
  logic [5:0] grp_code = '0;
  logic [7:0] key_out;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  key_chatter_filter #(.GROUP_W(4), .NUM_GROUPS(2), .BASE_SHIFT(SH)) i_key_chatter_filter (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .grp_code(grp_code), .key_out(key_out)
  );

  function automatic int period(input int c);
    int p = 1;
    for (int i = 0; i < SH; i++) p = p * 2;
    for (int i = 1; i < c; i++) p = p * 2;
    return p;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model, stepped on every rising edge
  logic [7:0] m_s1 = '0, m_s2 = '0, m_filt = '0, m_samp = '0;
  int m_cnt[2];
  int m_cp[2];

  always @(posedge clk) begin
    logic [7:0] exp_out;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_filt = '0; m_samp = '0;
      for (int g = 0; g < 2; g++) begin m_cnt[g] = 0; m_cp[g] = 0; end
    end else begin
      for (int g = 0; g < 2; g++) begin
        int c;
        c = int'(grp_code[g*3 +: 3]);
        for (int b = g*4; b < g*4+4; b++) begin
          if (c != m_cp[g]) begin
            if (m_cp[g] == 0) begin m_filt[b] = m_s2[b]; m_samp[b] = m_s2[b]; end
            else m_samp[b] = m_filt[b];
          end else if (c == 0) begin
            m_filt[b] = m_s2[b]; m_samp[b] = m_s2[b];
          end else if (m_cnt[g] == period(c) - 1) begin
            if (m_s2[b] == m_samp[b] && m_s2[b] != m_filt[b]) m_filt[b] = m_s2[b];
            m_samp[b] = m_s2[b];
          end
        end
        if (c != m_cp[g] || c == 0 || m_cnt[g] == period(c) - 1) m_cnt[g] = 0;
        else m_cnt[g]++;
        m_cp[g] = c;
      end
      m_s2 = m_s1;
      m_s1 = key_in;
      for (int b = 0; b < 8; b++) exp_out[b] = (m_cp[b/4] == 0) ? m_s2[b] : m_filt[b];
      #2;
      if (!done) check("R4/R6 model", key_out, exp_out);
    end
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finished");
      done = 1;
      finish_run();
    end
  end

  initial begin
    wait_neg(3);
    check("R1 reset held", key_out, 8'h00);
    rst_n = 1'b1;
    wait_neg(1);
    check("R1 after release", key_out, 8'h00);

    // R2: pass-through, two-cycle delay
    key_in = 8'hA5;
    wait_neg(1);
    check("R2 one cycle early", key_out, 8'h00);
    wait_neg(1);
    check("R2 after two cycles", key_out, 8'hA5);
    key_in = 8'h00;
    wait_neg(3);

    for (int c = 1; c <= 7; c++) begin
      int t, n;
      t = period(c);
      grp_code = {3'd0, 3'(c)};
      wait_neg(2*t + 4);
      // R5: pulse of one check time; R3: upper group stays pass-through
      key_in = 8'h91;
      wait_neg(2);
      check("R3 upper group pass-through", {key_out[7:4], 3'b000, key_out[0]}, 8'h90);
      wait_neg(t - 2);
      key_in = 8'h00;
      wait_neg(3*t);
      check("R5 pulse rejected", key_out, 8'h00);
      // R6: held level accepted within two check times
      key_in = 8'h01;
      n = 0;
      while (key_out[0] !== 1'b1 && n < 3*t + 8) begin wait_neg(1); n++; end
      check("R6 accept latency ok", 8'(n > t && n <= 2*t + 3), 8'h01);
      check("R6 level accepted", key_out, 8'h01);
      key_in = 8'h00;
      wait_neg(2*t + 4);
      check("R6 release accepted", key_out, 8'h00);
    end

    // R7: code write between filtering codes holds outputs
    grp_code = {3'd0, 3'd3};
    key_in = 8'h0F;
    wait_neg(2*period(3) + 4);
    check("R7 setup", key_out, 8'h0F);
    key_in = 8'h00;
    grp_code = {3'd0, 3'd4};
    begin
      bit held = 1;
      for (int i = 0; i < period(4); i++) begin
        wait_neg(1);
        if (key_out !== 8'h0F) held = 0;
      end
      check("R7 outputs held after write", 8'(held), 8'h01);
    end
    wait_neg(2*period(4) + 4);
    check("R7 new level after hold", key_out, 8'h00);

    // R8: bypass to filtering keeps level, both groups
    grp_code = 6'd0;
    key_in = 8'h6C;
    wait_neg(4);
    check("R8 bypass level", key_out, 8'h6C);
    grp_code = {3'd2, 3'd1};
    begin
      bit steady = 1;
      for (int i = 0; i < 3*period(2); i++) begin
        wait_neg(1);
        if (key_out !== 8'h6C) steady = 0;
      end
      check("R8 no glitch on switch", 8'(steady), 8'h01);
    end
    // R3: upper group filters independently of lower pass-through
    grp_code = {3'd2, 3'd0};
    wait_neg(2);
    key_in = 8'h93;
    wait_neg(3);
    check("R3 lower passes, upper held", key_out, 8'h63);
    wait_neg(2*period(2) + 4);
    check("R3 upper accepted", key_out, 8'h93);

    done = 1;
    finish_run();
  end
endmodule